// File: doc/BRIEF.md
# Capture-Compare Timer

A 32-bit up-counting timer on a simple register port with a combinational read path. The counter runs from the module clock, either every cycle or through a power-of-two prescaler. When it passes all-ones it either reloads from a load register for periodic operation, or it wraps to zero and stops for one-shot operation. A compare register raises a match event when the running count reaches it. An external input can be captured on a chosen edge, either on every qualifying edge or as a pair of edges into two capture registers.

Three event sources share one interrupt line: capture, overflow and match. Each source has a raw pending bit that sets on its event. An enable bit gates the source and is changed through separate write-one-to-set and write-one-to-clear registers. A write-one-to-clear status register shows the enabled pending bits. One output pin gives a pulse or a toggle on overflow, or on overflow and match, around a programmable idle level. A soft reset returns every register to its default over a few cycles, and a configuration bit shows when it is still in progress.

Register map (byte offsets): 0x00 identity (read only), 0x10 configuration (bit 0 = soft reset busy), 0x20 end-of-interrupt (reads zero, writes ignored), 0x24 raw pending, 0x28 enabled pending / clear, 0x2C enable set, 0x30 enable clear, 0x38 control, 0x3C counter, 0x40 load, 0x44 reload trigger, 0x48 posted status (reads zero), 0x4C match, 0x50 first capture, 0x54 interface control, 0x58 second capture. Interrupt bits are the same in every interrupt register: bit 0 capture, bit 1 overflow, bit 2 match. Control layout: bit 0 run, bit 1 auto-reload, bits 4:2 prescale value, bit 5 prescale enable, bit 6 compare enable, bit 7 output idle high, bits 9:8 capture edge, bits 11:10 output event select, bit 12 output toggle, bit 13 paired capture.

Top module: `tmr_core`

## Requirements
- R1: After reset the control, counter, load, match, capture, enable and pending registers read 0, offset 0x00 reads the identity value 0x4D540102, offsets 0x48, 0x20 and 0x54 read 0, and irqOut and pwmOut are 0.
- R2: With run set and prescale disabled, the counter increases by one on every clock edge. With run clear it holds its value.
- R3: With prescale enabled and prescale value p, the counter advances once per 2^(p+1) clocks, counted from the edge that sets run.
- R4: A counter-register write takes effect on the next edge, whether or not the counter runs. Any write to the reload trigger offset copies the load register into the counter.
- R5: When the counter ticks from 0xFFFFFFFF with auto-reload set, it becomes the load value and raw bit 1 sets. A load of L therefore gives an overflow every 2^32-L ticks.
- R6: When the counter ticks from 0xFFFFFFFF with auto-reload clear, it becomes 0, the run bit clears and raw bit 1 sets.
- R7: With compare enabled, raw bit 2 sets once on the edge after the counter reaches the match value. It does not set again while the counter holds that value.
- R8: In single-capture mode, an input edge of the kind chosen by control bits 9:8 (01 rising, 10 falling, 11 both, 00 none) copies the counter into the first capture register and sets raw bit 0. Other edges change neither. The input passes two synchronising flops first.
- R9: In paired-capture mode (control bit 13), the first qualifying edge goes to the first capture register without setting raw bit 0. The next one goes to the second capture register and sets raw bit 0. A control write restarts the pairing.
- R10: Writing ones to 0x2C sets enable bits, and writing ones to 0x30 clears them. Offset 0x28 reads raw AND enable, and ones written to it clear raw bits. irqOut is 1 exactly when an enabled bit is pending. A new event wins over a clear in the same cycle.
- R11: pwmOut equals the idle level (control bit 7) XOR an internal state. In pulse mode the state is 1 for the one cycle after a selected event. In toggle mode (bit 12) it flips on each selected event. Select 01 picks overflow, 10 picks overflow or match, and 00 or 11 picks nothing and holds the state at 0 in pulse mode.
- R12: Writing bit 1 of 0x54 starts a soft reset. Configuration bit 0 then reads 1 for RESET_CYCLES edges, register writes are ignored, and every register returns to its reset value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register byte offset |
| busWe | input | 1 | Write strobe, sampled on the rising clock edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| capIn | input | 1 | External capture input, asynchronous |
| pwmOut | output | 1 | Event output pin |
| irqOut | output | 1 | Interrupt request, high while any enabled event is pending |

## Verification
The assertions take the register port to be synchronous: address, write strobe and data must be stable around each rising edge, and reset must be a clean level. The properties on a stopped counter and on one-shot termination also assume that no counter, trigger or control write lands in the same cycle as the event they describe. The bench changes the port only a few nanoseconds after a rising edge and holds it for the whole cycle. It changes capIn only at those points, so the synchroniser latency is a fixed three edges. Its random counter values, match values and prescale settings are chosen so that no unplanned overflow falls inside a check window.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 8;
  localparam int PRE_W  = 3;

  localparam logic [ADDR_W-1:0] A_ID    = 8'h00;
  localparam logic [ADDR_W-1:0] A_CFG   = 8'h10;
  localparam logic [ADDR_W-1:0] A_EOI   = 8'h20;
  localparam logic [ADDR_W-1:0] A_RAW   = 8'h24;
  localparam logic [ADDR_W-1:0] A_STS   = 8'h28;
  localparam logic [ADDR_W-1:0] A_ENSET = 8'h2C;
  localparam logic [ADDR_W-1:0] A_ENCLR = 8'h30;
  localparam logic [ADDR_W-1:0] A_CTRL  = 8'h38;
  localparam logic [ADDR_W-1:0] A_CNT   = 8'h3C;
  localparam logic [ADDR_W-1:0] A_LOAD  = 8'h40;
  localparam logic [ADDR_W-1:0] A_TRIG  = 8'h44;
  localparam logic [ADDR_W-1:0] A_POST  = 8'h48;
  localparam logic [ADDR_W-1:0] A_MATCH = 8'h4C;
  localparam logic [ADDR_W-1:0] A_CAP1  = 8'h50;
  localparam logic [ADDR_W-1:0] A_IFC   = 8'h54;
  localparam logic [ADDR_W-1:0] A_CAP2  = 8'h58;

  // control word; field positions are software visible
  typedef struct packed {
    logic             capPaired;  // 13
    logic             outToggle;  // 12
    logic [1:0]       outSel;     // 11:10
    logic [1:0]       capEdge;    // 9:8
    logic             idleHigh;   // 7
    logic             cmpEn;      // 6
    logic             preEn;      // 5
    logic [PRE_W-1:0] preVal;     // 4:2
    logic             autoLoad;   // 1
    logic             run;        // 0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // events, bit 0 capture, bit 1 overflow, bit 2 match
  typedef struct packed {
    logic mat;
    logic ovf;
    logic cap;
  } evt_t;

  localparam int NUM_EVT = $bits(evt_t);

  // strobes from control to datapath
  typedef struct packed {
    logic cntWr;
    logic trigWr;
    logic ctrlWr;
    logic clear;
  } strobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int          W            = 32,
  parameter int          RESET_CYCLES = 4,
  parameter logic [31:0] ID_VALUE     = 32'h4D54_0102
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [W-1:0]      busWdata,
  output logic [W-1:0]      busRdata,
  input  evt_t              evt,
  input  logic [W-1:0]      cntVal,
  input  logic [W-1:0]      cap1Val,
  input  logic [W-1:0]      cap2Val,
  output ctrl_t             ctrlQ,
  output logic [W-1:0]      loadQ,
  output logic [W-1:0]      matchQ,
  output strobe_t           stb,
  output logic [NUM_EVT-1:0] rawSts,
  output logic [NUM_EVT-1:0] irqEn,
  output logic              rstBusy,
  output logic              irqOut
);
  localparam int BW = $clog2(RESET_CYCLES + 1);

  logic [BW-1:0]      busyCnt;
  logic               wrOk;
  logic               wrCtrl, wrLoad, wrMatch, wrSet, wrClr, wrSts, wrIfc;
  logic [NUM_EVT-1:0] evtBits;
  logic [NUM_EVT-1:0] setMask, clrMask, stsMask;

  assign rstBusy = (busyCnt != '0);
  assign wrOk    = busWe && !rstBusy;
  assign wrCtrl  = wrOk && (busAddr == A_CTRL);
  assign wrLoad  = wrOk && (busAddr == A_LOAD);
  assign wrMatch = wrOk && (busAddr == A_MATCH);
  assign wrSet   = wrOk && (busAddr == A_ENSET);
  assign wrClr   = wrOk && (busAddr == A_ENCLR);
  assign wrSts   = wrOk && (busAddr == A_STS);
  assign wrIfc   = wrOk && (busAddr == A_IFC);

  assign evtBits = evt;
  assign setMask = wrSet ? busWdata[NUM_EVT-1:0] : '0;
  assign clrMask = wrClr ? busWdata[NUM_EVT-1:0] : '0;
  assign stsMask = wrSts ? busWdata[NUM_EVT-1:0] : '0;

  assign stb.cntWr  = wrOk && (busAddr == A_CNT);
  assign stb.trigWr = wrOk && (busAddr == A_TRIG);
  assign stb.ctrlWr = wrCtrl;
  assign stb.clear  = rstBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= '0;
    else if (rstBusy) busyCnt <= busyCnt - 1'b1;
    else if (wrIfc && busWdata[1]) busyCnt <= BW'(RESET_CYCLES);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= '0;
    else if (rstBusy) ctrlQ <= '0;
    else if (wrCtrl) ctrlQ <= ctrl_t'(busWdata[CTRL_W-1:0]);
    else if (evt.ovf && !ctrlQ.autoLoad) ctrlQ.run <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadQ  <= '0;
      matchQ <= '0;
    end else if (rstBusy) begin
      loadQ  <= '0;
      matchQ <= '0;
    end else begin
      if (wrLoad)  loadQ  <= busWdata;
      if (wrMatch) matchQ <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn  <= '0;
      rawSts <= '0;
    end else if (rstBusy) begin
      irqEn  <= '0;
      rawSts <= '0;
    end else begin
      irqEn  <= (irqEn | setMask) & ~clrMask;
      rawSts <= (rawSts & ~stsMask) | evtBits;
    end
  end

  assign irqOut = |(rawSts & irqEn);

  always_comb begin
    busRdata = '0;
    case (busAddr)
      A_ID:             busRdata = W'(ID_VALUE);
      A_CFG:            busRdata = W'(rstBusy);
      A_RAW:            busRdata = W'(rawSts);
      A_STS:            busRdata = W'(rawSts & irqEn);
      A_ENSET, A_ENCLR: busRdata = W'(irqEn);
      A_CTRL:           busRdata = W'(ctrlQ);
      A_CNT:            busRdata = cntVal;
      A_LOAD:           busRdata = loadQ;
      A_MATCH:          busRdata = matchQ;
      A_CAP1:           busRdata = cap1Val;
      A_CAP2:           busRdata = cap2Val;
      default:          busRdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_t        ctrlQ,
  input  strobe_t      stb,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] loadQ,
  input  logic [W-1:0] matchQ,
  input  logic         capIn,
  output logic [W-1:0] cntVal,
  output logic [W-1:0] cap1Val,
  output logic [W-1:0] cap2Val,
  output evt_t         evt,
  output logic         pwmOut
);
  localparam int PCW = 1 << PRE_W;

  logic [PCW-1:0]   preCnt;
  logic [PCW-1:0]   preLimit;
  logic [PRE_W:0]   shAmt;
  logic             tick;
  logic             atMax;
  logic             matchHit, matchPrev;
  logic [1:0]       capSync;
  logic             capPrev, rise, fall, capQual, capPhase;
  logic             outEvt, outState;

  // divide by 2^(p+1)
  assign shAmt    = {1'b0, ctrlQ.preVal} + 1'b1;
  assign preLimit = PCW'(((PCW+1)'(1) << shAmt) - (PCW+1)'(1));
  assign tick     = ctrlQ.run && (!ctrlQ.preEn || (preCnt == preLimit));
  assign atMax    = &cntVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else if (stb.clear || !ctrlQ.run || !ctrlQ.preEn) preCnt <= '0;
    else if (preCnt == preLimit) preCnt <= '0;
    else preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntVal <= '0;
    else if (stb.clear) cntVal <= '0;
    else if (stb.cntWr) cntVal <= wdata;
    else if (stb.trigWr) cntVal <= loadQ;
    else if (tick) begin
      if (atMax) cntVal <= ctrlQ.autoLoad ? loadQ : '0;
      else cntVal <= cntVal + 1'b1;
    end
  end

  assign evt.ovf = tick && atMax && !stb.clear && !stb.cntWr && !stb.trigWr;

  // match fires on arrival only
  assign matchHit = ctrlQ.cmpEn && (cntVal == matchQ);
  assign evt.mat  = matchHit && !matchPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) matchPrev <= 1'b0;
    else matchPrev <= matchHit;
  end

  // capture input synchroniser and edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capSync <= '0;
      capPrev <= 1'b0;
    end else begin
      capSync <= {capSync[0], capIn};
      capPrev <= capSync[1];
    end
  end

  assign rise    = capSync[1] && !capPrev;
  assign fall    = !capSync[1] && capPrev;
  assign capQual = (ctrlQ.capEdge[0] && rise) || (ctrlQ.capEdge[1] && fall);
  assign evt.cap = capQual && (!ctrlQ.capPaired || capPhase) && !stb.clear;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cap1Val  <= '0;
      cap2Val  <= '0;
      capPhase <= 1'b0;
    end else if (stb.clear) begin
      cap1Val  <= '0;
      cap2Val  <= '0;
      capPhase <= 1'b0;
    end else if (stb.ctrlWr) begin
      capPhase <= 1'b0;
    end else if (capQual) begin
      if (ctrlQ.capPaired && capPhase) begin
        cap2Val  <= cntVal;
        capPhase <= 1'b0;
      end else begin
        cap1Val  <= cntVal;
        capPhase <= ctrlQ.capPaired;
      end
    end
  end

  // event output pin
  always_comb begin
    case (ctrlQ.outSel)
      2'b01:   outEvt = evt.ovf;
      2'b10:   outEvt = evt.ovf || evt.mat;
      default: outEvt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outState <= 1'b0;
    else if (stb.clear || (ctrlQ.outSel == 2'b00)) outState <= 1'b0;
    else if (ctrlQ.outToggle) outState <= outState ^ outEvt;
    else outState <= outEvt;
  end

  assign pwmOut = outState ^ ctrlQ.idleHigh;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int          W            = 32,
  parameter int          RESET_CYCLES = 4,
  parameter logic [31:0] ID_VALUE     = 32'h4D54_0102
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [7:0]   busAddr,
  input  logic         busWe,
  input  logic [W-1:0] busWdata,
  output logic [W-1:0] busRdata,
  input  logic         capIn,
  output logic         pwmOut,
  output logic         irqOut
);
  ctrl_t              ctrlQ;
  strobe_t            stb;
  evt_t               evtV;
  logic [W-1:0]       loadQ, matchQ, cntVal, cap1Val, cap2Val;
  logic [NUM_EVT-1:0] rawSts, irqEn;
  logic               rstBusy;

  tmr_ctrl #(.W(W), .RESET_CYCLES(RESET_CYCLES), .ID_VALUE(ID_VALUE)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .evt(evtV), .cntVal(cntVal),
    .cap1Val(cap1Val), .cap2Val(cap2Val), .ctrlQ(ctrlQ), .loadQ(loadQ),
    .matchQ(matchQ), .stb(stb), .rawSts(rawSts), .irqEn(irqEn),
    .rstBusy(rstBusy), .irqOut(irqOut)
  );

  tmr_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrlQ(ctrlQ), .stb(stb), .wdata(busWdata),
    .loadQ(loadQ), .matchQ(matchQ), .capIn(capIn), .cntVal(cntVal),
    .cap1Val(cap1Val), .cap2Val(cap2Val), .evt(evtV), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic [7:0]         busAddr,
  input logic               busWe,
  input ctrl_t              ctrlQ,
  input logic [W-1:0]       cntVal,
  input logic               ovfEvt,
  input logic [NUM_EVT-1:0] rawSts,
  input logic               rstBusy,
  input logic               irqOut,
  input logic               pwmOut
);
  logic cntTouch, ctrlTouch;
  assign cntTouch  = busWe && ((busAddr == A_CNT) || (busAddr == A_TRIG));
  assign ctrlTouch = busWe && (busAddr == A_CTRL);

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ.run && !rstBusy && !cntTouch) |=> $stable(cntVal)); // R2

  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (ovfEvt && !rstBusy) |=> rawSts[1]); // R5

  AST_ONESHOT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ovfEvt && !ctrlQ.autoLoad) |=> (cntVal == '0)); // R6

  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rstN)
    (ovfEvt && !ctrlQ.autoLoad && !rstBusy && !ctrlTouch) |=> !ctrlQ.run); // R6

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ.outSel == 2'b00) |=> (pwmOut == ctrlQ.idleHigh)); // R11

  AST_RST_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    rstBusy |=> ((rawSts == '0) && (ctrlQ == '0) && !irqOut)); // R12
endmodule

bind tmr_core tmr_checker #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .ctrlQ(ctrlQ),
  .cntVal(cntVal), .ovfEvt(evtV.ovf), .rawSts(rawSts), .rstBusy(rstBusy),
  .irqOut(irqOut), .pwmOut(pwmOut)
);

// File: tb/tmr_core_tb.sv
module tmr_core_tb;
  localparam logic [7:0] O_ID = 8'h00, O_CFG = 8'h10, O_EOI = 8'h20, O_RAW = 8'h24,
    O_STS = 8'h28, O_SET = 8'h2C, O_CLR = 8'h30, O_CTL = 8'h38, O_CNT = 8'h3C,
    O_LOAD = 8'h40, O_TRIG = 8'h44, O_POST = 8'h48, O_MAT = 8'h4C, O_CAP1 = 8'h50,
    O_IFC = 8'h54, O_CAP2 = 8'h58;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        capIn = 1'b0;
  logic        pwmOut, irqOut;
  int          nChecks = 0;
  int          nErr = 0;

  always #10 clk = ~clk;

  tmr_core u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .capIn(capIn),
    .pwmOut(pwmOut), .irqOut(irqOut)
  );

  function automatic logic [31:0] preExpect(input int ticks, input int p);
    return 32'(ticks >> (p + 1));
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk);
    #2 busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic chkReg(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, c1, c2, c3, c4, m, ldv;
    void'($urandom(32'd2718));
    edges(3);
    rstN = 1'b1;
    edges(1);

    // R1 reset state
    chkReg("R1 id", O_ID, 32'h4D54_0102);
    chkReg("R1 ctrl", O_CTL, 0);
    chkReg("R1 cnt", O_CNT, 0);
    chkReg("R1 enable", O_SET, 0);
    chkReg("R1 posted", O_POST, 0);
    chkReg("R1 eoi", O_EOI, 0);
    chkReg("R1 ifc", O_IFC, 0);
    check("R1 irq", 32'(irqOut), 0);
    check("R1 pwm", 32'(pwmOut), 0);

    // R4 random direct writes
    for (int i = 0; i < 8; i++) begin
      v = $urandom;
      wr(O_CNT, v);
      chkReg("R4 cnt write", O_CNT, v);
    end
    wr(O_LOAD, 32'h55);
    wr(O_CNT, 32'h1234);
    wr(O_TRIG, 32'h0);
    chkReg("R4 trigger reload", O_CNT, 32'h55);

    // R2 free run and hold
    wr(O_CNT, 100);
    wr(O_CTL, 32'h1);
    edges(7);
    chkReg("R2 run", O_CNT, 107);
    wr(O_CTL, 32'h0);
    edges(5);
    chkReg("R2 hold", O_CNT, 108);

    // R3 prescaler, random plus directed maximum
    for (int i = 0; i < 7; i++) begin
      int p, k;
      p = (i == 6) ? 7 : int'($urandom % 8);
      k = (i == 6) ? 600 : int'($urandom % 300) + 1;
      wr(O_CTL, 0);
      wr(O_CNT, 0);
      wr(O_CTL, 32'h21 | (32'(p) << 2));
      edges(k);
      chkReg("R3 prescale", O_CNT, preExpect(k, p));
    end

    // R5 auto-reload overflow, R10 interrupt
    wr(O_CTL, 0);
    wr(O_STS, 7);
    wr(O_SET, 2);
    ldv = 32'hFFFF_FFFE - 32'd3;
    wr(O_LOAD, ldv);
    wr(O_CNT, ldv);
    wr(O_CTL, 32'h3);
    edges(4);
    chkReg("R5 at max", O_CNT, 32'hFFFF_FFFF);
    chkReg("R5 no flag yet", O_RAW, 0);
    check("R10 irq idle", 32'(irqOut), 0);
    edges(1);
    chkReg("R5 reload", O_CNT, ldv);
    chkReg("R5 flag", O_RAW, 2);
    chkReg("R10 masked", O_STS, 2);
    check("R10 irq high", 32'(irqOut), 1);
    edges(5);
    chkReg("R5 period", O_CNT, ldv);
    wr(O_STS, 2);
    chkReg("R10 w1c", O_RAW, 0);
    check("R10 irq cleared", 32'(irqOut), 0);
    wr(O_CTL, 0);

    // R10 enable set and clear
    wr(O_CLR, 7);
    chkReg("R10 clr all", O_SET, 0);
    wr(O_SET, 5);
    chkReg("R10 set", O_SET, 5);
    chkReg("R10 clr view", O_CLR, 5);
    wr(O_CLR, 4);
    chkReg("R10 clr one", O_SET, 1);

    // R6 one-shot
    wr(O_STS, 7);
    wr(O_CNT, 32'hFFFF_FFFE);
    wr(O_CTL, 32'h1);
    edges(2);
    chkReg("R6 wrap zero", O_CNT, 0);
    chkReg("R6 run cleared", O_CTL, 0);
    chkReg("R6 flag", O_RAW, 2);
    edges(3);
    chkReg("R6 stays", O_CNT, 0);

    // R7 match with R11 pulse output
    wr(O_STS, 7);
    m = ($urandom & 32'h7FFF_FFFF) + 32'd10;
    wr(O_MAT, m);
    wr(O_CNT, m - 32'd5);
    wr(O_CTL, 32'h1 | 32'h40 | (32'h2 << 10));
    edges(5);
    chkReg("R7 reach", O_CNT, m);
    chkReg("R7 not yet", O_RAW, 0);
    check("R11 pulse idle", 32'(pwmOut), 0);
    edges(1);
    chkReg("R7 flag", O_RAW, 4);
    check("R11 pulse high", 32'(pwmOut), 1);
    edges(1);
    check("R11 pulse end", 32'(pwmOut), 0);
    wr(O_STS, 4);
    edges(3);
    chkReg("R7 once", O_RAW, 0);

    // R11 toggle on overflow, idle high
    wr(O_CTL, 0);
    wr(O_CNT, 32'hFFFF_FFFD);
    wr(O_CTL, 32'h3 | 32'h80 | (32'h1 << 10) | (32'h1 << 12));
    edges(2);
    check("R11 toggle idle", 32'(pwmOut), 1);
    edges(1);
    check("R11 toggle flip", 32'(pwmOut), 0);
    edges(5);
    check("R11 toggle back", 32'(pwmOut), 1);
    wr(O_CTL, 32'h80);
    edges(2);
    check("R11 off idle high", 32'(pwmOut), 1);

    // R8 single capture edges
    wr(O_STS, 7);
    c1 = $urandom;
    wr(O_CNT, c1);
    wr(O_CTL, 32'h1 << 8);
    capIn = 1'b1;
    edges(4);
    chkReg("R8 rising cap", O_CAP1, c1);
    chkReg("R8 rising flag", O_RAW, 1);
    wr(O_STS, 1);
    wr(O_CNT, $urandom);
    capIn = 1'b0;
    edges(4);
    chkReg("R8 fall ignored", O_CAP1, c1);
    chkReg("R8 fall no flag", O_RAW, 0);
    wr(O_CTL, 32'h2 << 8);
    c2 = $urandom;
    wr(O_CNT, c2);
    capIn = 1'b1;
    edges(4);
    chkReg("R8 rise ignored", O_CAP1, c1);
    capIn = 1'b0;
    edges(4);
    chkReg("R8 falling cap", O_CAP1, c2);
    chkReg("R8 falling flag", O_RAW, 1);
    wr(O_STS, 1);
    wr(O_CTL, 32'h3 << 8);
    c3 = $urandom;
    wr(O_CNT, c3);
    capIn = 1'b1;
    edges(4);
    chkReg("R8 both rise", O_CAP1, c3);
    c4 = $urandom;
    wr(O_CNT, c4);
    capIn = 1'b0;
    edges(4);
    chkReg("R8 both fall", O_CAP1, c4);

    // R9 paired capture
    wr(O_STS, 7);
    wr(O_CTL, (32'h1 << 8) | (32'h1 << 13));
    c1 = $urandom;
    wr(O_CNT, c1);
    capIn = 1'b1;
    edges(4);
    chkReg("R9 first", O_CAP1, c1);
    chkReg("R9 first no flag", O_RAW, 0);
    capIn = 1'b0;
    edges(4);
    c2 = $urandom;
    wr(O_CNT, c2);
    capIn = 1'b1;
    edges(4);
    chkReg("R9 second", O_CAP2, c2);
    chkReg("R9 first kept", O_CAP1, c1);
    chkReg("R9 flag", O_RAW, 1);
    capIn = 1'b0;
    edges(4);

    // R12 soft reset
    wr(O_SET, 7);
    wr(O_LOAD, 123);
    wr(O_CTL, 32'h41);
    wr(O_IFC, 2);
    chkReg("R12 busy", O_CFG, 1);
    wr(O_LOAD, 99);
    edges(2);
    chkReg("R12 still busy", O_CFG, 1);
    edges(1);
    chkReg("R12 done", O_CFG, 0);
    chkReg("R12 ctrl", O_CTL, 0);
    chkReg("R12 load", O_LOAD, 0);
    chkReg("R12 enable", O_SET, 0);
    chkReg("R12 cnt", O_CNT, 0);
    chkReg("R12 raw", O_RAW, 0);
    chkReg("R12 cap", O_CAP1, 0);
    check("R12 irq", 32'(irqOut), 0);

    summary();
    $finish;
  end
endmodule